// File: doc/BRIEF.md
# RAID6 P+Q Parity Stream Engine

This block computes the two check streams used by dual-parity disk arrays. It accepts source bytes one at a time over a valid/ready input and builds two results for every byte position. P is the bytewise XOR of the sources. Q is the XOR of the sources after each one has been multiplied in GF(2^8) by a coefficient that belongs to that source. A single accumulator pair takes one source byte per clock. When the last source byte for a position has been accepted, the block emits P and Q in registered form, together with a flag that marks the final position.

An operation is set up with a start pulse. The pulse loads the mode, the number of sources, a 24-bit byte count and the per-source coefficients. In XOR-only mode the block produces P and drives Q to zero. In the incremental update mode each position takes two data bytes and then the existing P and Q bytes, and the block produces refreshed P and Q. A done pulse follows the final output.

Top module: `raid_pq_engine`

## Requirements
- R1: While reset is held and in the cycle after it is released, `src_ready`, `out_valid`, `out_last` and `done` are 0, and `out_p` and `out_q` are 0x00.
- R2: A pulse on `cfg_start` while the block is idle begins an operation. The block then accepts one byte per cycle in which `src_valid` and `src_ready` are both 1. For each position the bytes arrive in source order, source 0 first. `out_p` is the XOR of the `cfg_nsrc` bytes of that position.
- R3: In mode 1 (P+Q), `out_q` is the XOR over sources i of the GF(2^8) product of byte i and coefficient i. Coefficient i is taken from `cfg_coef[8i+7:8i]`.
- R4: GF(2^8) products are reduced by x^8+x^4+x^3+x^2+1. For example, 0x80 times 0x02 is 0x1D, and 0xFF times 0x02 is 0xE3.
- R5: The mode is encoded as 0 for XOR-only, 1 for P+Q, 2 for update; 3 behaves as 1. In mode 0, `out_q` is 0x00 on every output.
- R6: In mode 2 each position takes four beats in this order: data byte d0, data byte d1, old P, old Q. The block gives out_p = d0^d1^oldP and out_q = c0·d0 ^ c1·d1 ^ oldQ.
- R7: `out_valid` is high for exactly one cycle per position, in the cycle after the edge that accepts that position's final beat. `out_last` is high only with the output of position `cfg_len`-1.
- R8: `done` pulses for one cycle, in the cycle after the output marked last. `src_ready` falls in the same cycle as that last output.
- R9: A `cfg_start` pulse during a busy operation is ignored. The mode, length and coefficients already loaded stay in use.
- R10: Cycles in which `src_valid` is low are not counted as beats and do not change any result.
- R11: Up to 16 sources are combined per position. A `cfg_nsrc` of 16 uses every coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start pulse; loads the configuration when idle |
| cfg_mode | input | 2 | 0 XOR-only, 1 P+Q, 2 update |
| cfg_nsrc | input | 5 | Source count, 1 to 16 |
| cfg_len | input | 24 | Number of byte positions |
| cfg_coef | input | 128 | Per-source GF coefficients, source i in bits [8i+7:8i] |
| src_valid | input | 1 | Source byte present |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | High while an operation is accepting bytes |
| out_valid | output | 1 | One-cycle strobe for a completed position |
| out_p | output | 8 | P result |
| out_q | output | 8 | Q result |
| out_last | output | 1 | Marks the final position |
| done | output | 1 | One-cycle pulse after the final output |

## Verification
In XOR-only mode with three sources, the bench confirms that P is computed and that Q stays zero. A run with all sixteen sources and random coefficients exposes any error in coefficient indexing or in the GF multiply. A run with a single source, coefficient 2, and the bytes 0x80 and 0xFF isolates the reduction polynomial. The update mode separates the roles of the four beats. Runs with idle input cycles and with a start pulse sent mid-operation show that neither one disturbs the result. Each position's output strobe, the last flag and the done pulse are sampled at their exact cycles.

// File: rtl/raid_pq_pkg.sv
package raid_pq_pkg;
  typedef enum logic [1:0] {
    MODE_XOR = 2'd0,
    MODE_PQ  = 2'd1,
    MODE_UPD = 2'd2,
    MODE_ALT = 2'd3
  } pq_mode_e;
endpackage

// File: rtl/raid_gf_mul.sv
module raid_gf_mul #(
  parameter logic [7:0] POLY_LO = 8'h1D
) (
  input  logic [7:0] op_a,
  input  logic [7:0] op_b,
  output logic [7:0] prod
);
  logic [7:0] shifted [0:8];
  logic [7:0] partial [0:8];

  assign shifted[0] = op_a;
  assign partial[0] = 8'h00;

  // one shift-and-reduce stage per multiplier bit
  for (genvar g = 0; g < 8; g++) begin : g_stage
    assign partial[g+1] = op_b[g] ? (partial[g] ^ shifted[g]) : partial[g];
    assign shifted[g+1] = {shifted[g][6:0], 1'b0} ^ (shifted[g][7] ? POLY_LO : 8'h00);
  end

  assign prod = partial[8];
endmodule

// File: rtl/raid_pq_seq.sv
module raid_pq_seq
  import raid_pq_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int LEN_W   = 24,
  localparam int SRC_W  = $clog2(MAX_SRC + 1),
  localparam int IDX_W  = ($clog2(MAX_SRC) < 2) ? 2 : $clog2(MAX_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode_in,
  input  logic [SRC_W-1:0] nsrc_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             beat,
  output logic             busy,
  output pq_mode_e         mode_q,
  output logic [IDX_W-1:0] idx,
  output logic             pos_end,
  output logic             pos_last
);
  logic [IDX_W-1:0] term_max_q;
  logic [LEN_W-1:0] rem_q;
  logic [IDX_W-1:0] term_max_nx;

  always_comb begin
    if (pq_mode_e'(mode_in) == MODE_UPD)
      term_max_nx = IDX_W'(3);
    else if (nsrc_in == '0)
      term_max_nx = '0;
    else if (int'(nsrc_in) > MAX_SRC)
      term_max_nx = IDX_W'(MAX_SRC - 1);
    else
      term_max_nx = IDX_W'(nsrc_in - SRC_W'(1));
  end

  assign pos_end  = (idx == term_max_q);
  assign pos_last = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      mode_q     <= MODE_XOR;
      term_max_q <= '0;
      rem_q      <= '0;
      idx        <= '0;
    end else if (start && !busy) begin
      busy       <= 1'b1;
      mode_q     <= pq_mode_e'(mode_in);
      term_max_q <= term_max_nx;
      rem_q      <= (len_in == '0) ? '0 : len_in - LEN_W'(1);
      idx        <= '0;
    end else if (beat) begin
      if (pos_end) begin
        idx <= '0;
        if (pos_last) busy <= 1'b0;
        else          rem_q <= rem_q - LEN_W'(1);
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/raid_pq_acc.sv
module raid_pq_acc (
  input  logic       clk,
  input  logic       rst,
  input  logic       beat,
  input  logic       first,
  input  logic       pos_end,
  input  logic       pos_last,
  input  logic [7:0] p_term,
  input  logic [7:0] q_term,
  output logic       out_valid,
  output logic       out_last,
  output logic [7:0] out_p,
  output logic [7:0] out_q
);
  logic [7:0] acc_p, acc_q;
  logic [7:0] acc_p_nx, acc_q_nx;

  assign acc_p_nx = (first ? 8'h00 : acc_p) ^ p_term;
  assign acc_q_nx = (first ? 8'h00 : acc_q) ^ q_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_p     <= 8'h00;
      acc_q     <= 8'h00;
      out_p     <= 8'h00;
      out_q     <= 8'h00;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= beat && pos_end;
      out_last  <= beat && pos_end && pos_last;
      if (beat) begin
        acc_p <= acc_p_nx;
        acc_q <= acc_q_nx;
      end
      if (beat && pos_end) begin
        out_p <= acc_p_nx;
        out_q <= acc_q_nx;
      end
    end
  end
endmodule

// File: rtl/raid_pq_engine.sv
module raid_pq_engine
  import raid_pq_pkg::*;
#(
  parameter int          MAX_SRC = 16,
  parameter int          LEN_W   = 24,
  parameter logic [7:0]  POLY_LO = 8'h1D,
  localparam int SRC_W = $clog2(MAX_SRC + 1),
  localparam int IDX_W = ($clog2(MAX_SRC) < 2) ? 2 : $clog2(MAX_SRC),
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_start,
  input  logic [1:0]           cfg_mode,
  input  logic [SRC_W-1:0]     cfg_nsrc,
  input  logic [LEN_W-1:0]     cfg_len,
  input  logic [MAX_SRC*8-1:0] cfg_coef,
  input  logic                 src_valid,
  input  logic [7:0]           src_data,
  output logic                 src_ready,
  output logic                 out_valid,
  output logic [7:0]           out_p,
  output logic [7:0]           out_q,
  output logic                 out_last,
  output logic                 done
);
  logic             busy, beat, pos_end, pos_last;
  logic [IDX_W-1:0] idx;
  pq_mode_e         mode_q;
  logic [7:0]       coef_mem [DEPTH];
  logic [7:0]       coef_sel, gf_prod, p_term, q_term;

  assign src_ready = busy;
  assign beat      = src_valid && busy;

  always_ff @(posedge clk) begin
    if (cfg_start && !busy) begin
      for (int i = 0; i < DEPTH; i++)
        coef_mem[i] <= (i < MAX_SRC) ? cfg_coef[(i % MAX_SRC)*8 +: 8] : 8'h00;
    end
  end

  assign coef_sel = coef_mem[idx];

  raid_pq_seq #(.MAX_SRC(MAX_SRC), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .start(cfg_start), .mode_in(cfg_mode),
    .nsrc_in(cfg_nsrc), .len_in(cfg_len), .beat(beat), .busy(busy),
    .mode_q(mode_q), .idx(idx), .pos_end(pos_end), .pos_last(pos_last)
  );

  raid_gf_mul #(.POLY_LO(POLY_LO)) u_mul (
    .op_a(src_data), .op_b(coef_sel), .prod(gf_prod)
  );

  always_comb begin
    p_term = src_data;
    q_term = gf_prod;
    case (mode_q)
      MODE_XOR: q_term = 8'h00;
      MODE_UPD: begin
        if (idx == IDX_W'(2)) q_term = 8'h00;
        if (idx == IDX_W'(3)) begin
          p_term = 8'h00;
          q_term = src_data;
        end
      end
      default: ;
    endcase
  end

  raid_pq_acc u_acc (
    .clk(clk), .rst(rst), .beat(beat), .first(idx == '0),
    .pos_end(pos_end), .pos_last(pos_last), .p_term(p_term), .q_term(q_term),
    .out_valid(out_valid), .out_last(out_last), .out_p(out_p), .out_q(out_q)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= out_valid && out_last;
  end
endmodule

// File: rtl/raid_pq_engine_chk.sv
module raid_pq_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_start,
  input logic       src_ready,
  input logic       out_valid,
  input logic       out_last,
  input logic [7:0] out_q,
  input logic       done,
  input logic [1:0] mode_q
);
  assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_done_follows_last_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_last));

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(src_ready) |-> (out_valid && out_last));

  assert_xor_q_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == 2'd0) |-> (out_q == 8'h00));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_start && src_ready) |=> $stable(mode_q));
endmodule

bind raid_pq_engine raid_pq_engine_chk u_chk (
  .clk(clk), .rst(rst), .cfg_start(cfg_start), .src_ready(src_ready),
  .out_valid(out_valid), .out_last(out_last), .out_q(out_q), .done(done),
  .mode_q(mode_q)
);

// File: tb/raid_pq_engine_test.sv
`timescale 1ns/1ps
module raid_pq_engine_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_start = 1'b0;
  logic [1:0]   cfg_mode = 2'd0;
  logic [4:0]   cfg_nsrc = 5'd1;
  logic [23:0]  cfg_len = 24'd1;
  logic [127:0] cfg_coef = '0;
  logic         src_valid = 1'b0;
  logic [7:0]   src_data = 8'h00;
  logic         src_ready, out_valid, out_last, done;
  logic [7:0]   out_p, out_q;

  int n_checks = 0;
  int n_fail   = 0;
  int vcount   = 0;
  logic [7:0] stim [0:7][0:15];
  logic [7:0] coef [0:15];

  raid_pq_engine uut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_nsrc(cfg_nsrc), .cfg_len(cfg_len), .cfg_coef(cfg_coef),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .out_valid(out_valid), .out_p(out_p), .out_q(out_q),
    .out_last(out_last), .done(done)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (!rst && out_valid) vcount++;

  // carry-less product followed by reduction from the top bit down
  function automatic logic [7:0] gfm(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] w = '0;
    for (int i = 0; i < 8; i++) if (b[i]) w ^= 15'(a) << i;
    for (int k = 14; k >= 8; k--) if (w[k]) w ^= 15'h11D << (k - 8);
    return w[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int len, input int terms);
    for (int p = 0; p < len; p++)
      for (int t = 0; t < terms; t++) stim[p][t] = 8'($urandom);
    for (int s = 0; s < 16; s++) cfg_coef[s*8 +: 8] = coef[s];
  endtask

  task automatic run_op(input int mode, input int nsrc, input int len,
                        input bit gaps, input bit inject, input string req);
    int terms = (mode == 2) ? 4 : nsrc;
    logic [7:0] ep, eq;
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_nsrc = 5'(nsrc); cfg_len = 24'(len); cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    vcount = 0;
    for (int p = 0; p < len; p++) begin
      ep = 8'h00; eq = 8'h00;
      for (int t = 0; t < terms; t++) begin
        if (mode == 2) begin
          if (t < 2)  begin ep ^= stim[p][t]; eq ^= gfm(stim[p][t], coef[t]); end
          if (t == 2) ep ^= stim[p][t];
          if (t == 3) eq ^= stim[p][t];
        end else begin
          ep ^= stim[p][t];
          if (mode != 0) eq ^= gfm(stim[p][t], coef[t]);
        end
        if (gaps && (t % 2 == 1)) begin
          src_valid = 1'b0;
          @(negedge clk);
        end
        src_valid = 1'b1;
        src_data  = stim[p][t];
        if (inject && p == 1 && t == 0) begin
          cfg_start = 1'b1; cfg_mode = 2'd0; cfg_len = 24'd1;
        end
        @(negedge clk);
        cfg_start = 1'b0;
      end
      chk(out_valid == 1'b1, req, "out_valid R7", int'(out_valid), 1);
      chk(out_p == ep, req, "out_p", int'(out_p), int'(ep));
      chk(out_q == eq, req, "out_q", int'(out_q), int'(eq));
      chk(out_last == (p == len - 1), "R7", "out_last", int'(out_last), int'(p == len - 1));
    end
    src_valid = 1'b0;
    chk(src_ready == 1'b0, "R8", "src_ready after final beat", int'(src_ready), 0);
    @(negedge clk);
    chk(done == 1'b1, "R8", "done pulse", int'(done), 1);
    chk(out_valid == 1'b0, "R7", "single strobe", int'(out_valid), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", int'(done), 0);
    chk(vcount == len, "R7", "strobe count", vcount, len);
  endtask

  task automatic t_reset;
    chk(src_ready == 1'b0 && out_valid == 1'b0 && done == 1'b0 && out_last == 1'b0,
        "R1", "control outputs", int'({src_ready, out_valid, done, out_last}), 0);
    chk(out_p == 8'h00 && out_q == 8'h00, "R1", "data outputs", int'({out_p, out_q}), 0);
  endtask

  task automatic t_xor_only;
    for (int s = 0; s < 16; s++) coef[s] = 8'($urandom) | 8'h01;
    fill(4, 3);
    run_op(0, 3, 4, 1'b0, 1'b0, "R2 R5");
  endtask

  task automatic t_pq_full;
    for (int s = 0; s < 16; s++) coef[s] = 8'($urandom);
    fill(3, 16);
    run_op(1, 16, 3, 1'b0, 1'b0, "R3 R11");
  endtask

  task automatic t_poly;
    coef[0] = 8'h02;
    fill(3, 1);
    stim[0][0] = 8'h80; stim[1][0] = 8'hFF; stim[2][0] = 8'h01;
    chk(gfm(8'h80, 8'h02) == 8'h1D && gfm(8'hFF, 8'h02) == 8'hE3, "R4",
        "bench model", int'(gfm(8'hFF, 8'h02)), 'hE3);
    run_op(1, 1, 3, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_update;
    for (int s = 0; s < 16; s++) coef[s] = 8'($urandom);
    fill(4, 4);
    run_op(2, 2, 4, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_mode3;
    for (int s = 0; s < 16; s++) coef[s] = 8'($urandom);
    fill(2, 4);
    run_op(3, 4, 2, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_gaps;
    for (int s = 0; s < 16; s++) coef[s] = 8'($urandom);
    fill(3, 5);
    run_op(1, 5, 3, 1'b1, 1'b0, "R10");
  endtask

  task automatic t_busy_start;
    for (int s = 0; s < 16; s++) coef[s] = 8'($urandom);
    fill(3, 2);
    run_op(1, 2, 3, 1'b0, 1'b1, "R9");
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_xor_only();
    t_pq_full();
    t_poly();
    t_update();
    t_mode3();
    t_gaps();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule